// File: doc/BRIEF.md
# Two-Wire Serial Program/Verify Target

This block is the device-side engine for a two-wire in-system programming port on a small flash microcontroller that stores 12-bit instruction words. An external programmer drives a serial clock and a data line. The block brings both into the system clock domain and turns clock edges into bit events. It collects 6-bit commands and moves 16-clock data frames in either direction. For reads, it drives a separate output and an output enable, which together form the pad's tristate control.

A word address counter walks user memory and then the small configuration region above it. The block turns each command into a single-cycle request to a synchronous memory model: read, program word, end programming, or bulk erase. On read-back, it hides protected user words when code protection is on. High-voltage mode entry is outside the block and arrives as a level input, `modeEn`. The code-protect bit of the configuration word arrives on `cpBit`.

Top module: `sp_target`

## Requirements
- R1: A command is 6 bits sent LSb first, and each bit is taken on a falling edge of `sClk`. Only the low 4 bits select the operation: 0x2 load, 0x4 read, 0x6 increment, 0x8 begin programming, 0xE end programming, 0x9 bulk erase. The upper 2 bits are ignored. Any other low-nibble code changes no address, state or memory request.
- R2: A load is followed by a 16-clock frame. The values on the 1st and 16th falling edges are ignored. The 14 bits between them are data, LSb first. Only the low 12 bits are kept as the word to program.
- R3: A read is followed by a 16-clock frame. `sDatOe` rises after the 2nd rising `sClk` edge and falls after the 16th. On the 2nd through 15th rising edges `sDatOut` presents the 14-bit value LSb first, with bits 13:12 always 0. `sDatOe` is low whenever `modeEn` is low.
- R4: A rising `modeEn` clears the address counter and selects the configuration word, so `memAddr` reads 0x1FF. It also clears `progErr` and any pending load. `progErr` is also held clear while `modeEn` is low.
- R5: The first increment after entry deselects the configuration word and leaves the counter at 0x000. Each later increment adds one, except that 0x0FF goes to 0x100 and 0x1FF goes to 0x000.
- R6: After that first increment, the configuration word cannot be reached. When the counter reaches 0x1FF, or any reserved address from 0x105 to 0x1FE, a read returns zero and begin-programming issues no write. Addresses 0x100–0x104 (user IDs and the backup calibration word) are reachable.
- R7: While `cpBit` is 0, reads of user addresses 0x040–0x0FE return zero. Addresses 0x000–0x03F, 0x0FF, configuration space and the configuration word read normally.
- R8: Begin programming issues one `memWrEn` pulse carrying `memAddr` and the loaded word, but only if a load has completed since the last begin-programming. Otherwise it issues no write and sets `progErr`, which stays set until the mode is left or re-entered.
- R9: End programming issues exactly one `memEndEn` pulse.
- R10: Bulk erase issues one `memEraseEn` pulse. `memEraseAll` goes high with the pulse only when the counter is in configuration space (0x100 and up) and the configuration word is not selected. `memEraseAll` tells the memory to also clear 0x100–0x104.
- R11: The memory strobes `memRdEn`, `memWrEn`, `memEndEn` and `memEraseEn` are single-cycle pulses, and at most one is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| modeEn | input | 1 | Program/verify mode active (level) |
| sClk | input | 1 | Serial clock from the programmer (asynchronous) |
| sDatIn | input | 1 | Serial data from the pad |
| cpBit | input | 1 | Code-protect bit of the configuration word, 0 = protected |
| sDatOut | output | 1 | Serial data to the pad during reads |
| sDatOe | output | 1 | Pad output enable for the data line |
| memAddr | output | 9 | Word address presented to memory |
| memRdEn | output | 1 | Read request pulse |
| memRdData | input | 12 | Read data, valid the cycle after `memRdEn` |
| memWrEn | output | 1 | Program-word request pulse |
| memWrData | output | 12 | Word to program |
| memEndEn | output | 1 | End-programming pulse |
| memEraseEn | output | 1 | Bulk-erase pulse |
| memEraseAll | output | 1 | Erase also covers user IDs and backup calibration |
| progErr | output | 1 | Sticky begin-without-load error |

## Verification
A serial edge reaches the block's edge detector after two synchronizer flops, and outputs driven from that event are registered one cycle later. `sDatOe` and `sDatOut` therefore settle about three system cycles after an `sClk` edge. The bench holds each `sClk` phase for eight cycles and samples the data pin six cycles after the rising edge. A decoded command raises its memory pulse on the cycle after the final falling-edge event, and read data is captured one cycle after `memRdEn`. The bench therefore leaves a twelve-cycle gap after every command before it looks at `memAddr`, `progErr` or the pulse counters, which a monitor collects on the falling clock edge.

// File: rtl/sp_pkg.sv
package sp_pkg;

  typedef enum logic [1:0] {
    ST_CMD,
    ST_LOAD,
    ST_READ
  } spState_e;

  localparam logic [3:0] OP_LOAD  = 4'h2;
  localparam logic [3:0] OP_READ  = 4'h4;
  localparam logic [3:0] OP_INC   = 4'h6;
  localparam logic [3:0] OP_BEGIN = 4'h8;
  localparam logic [3:0] OP_END   = 4'hE;
  localparam logic [3:0] OP_ERASE = 4'h9;

  // strobes from control to datapath, all single-cycle
  typedef struct packed {
    logic enter;
    logic bitVal;
    logic shiftIn;
    logic loadDone;
    logic doInc;
    logic doRead;
    logic doProg;
    logic doEnd;
    logic doErase;
    logic outStart;
    logic outShift;
    logic outStop;
  } spStrobe_t;

endpackage

// File: rtl/sp_ctrl.sv
module sp_ctrl
  import sp_pkg::*;
#(
  parameter int FRAME_CLKS = 16,
  parameter int CMD_BITS   = 6,
  localparam int CW        = $clog2(FRAME_CLKS)
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      modeEn,
  input  logic      sClk,
  input  logic      sDatIn,
  output spStrobe_t stb
);

  localparam logic [CW-1:0] LAST_CLK = CW'(FRAME_CLKS - 1);
  localparam logic [CW-1:0] LAST_CMD = CW'(CMD_BITS - 1);

  logic [1:0]          clkSync;
  logic [1:0]          datSync;
  logic                clkPrev;
  logic                modePrev;
  logic                rise;
  logic                fall;
  logic                enter;
  spState_e            state;
  logic [CW-1:0]       cnt;
  logic [CMD_BITS-2:0] cmdReg;

  assign rise  = clkSync[1] & ~clkPrev;
  assign fall  = ~clkSync[1] & clkPrev;
  assign enter = modeEn & ~modePrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkSync  <= '0;
      datSync  <= '0;
      clkPrev  <= 1'b0;
      modePrev <= 1'b0;
      state    <= ST_CMD;
      cnt      <= '0;
      cmdReg   <= '0;
    end else begin
      clkSync  <= {clkSync[0], sClk};
      datSync  <= {datSync[0], sDatIn};
      clkPrev  <= clkSync[1];
      modePrev <= modeEn;
      if (!modeEn || enter) begin
        state <= ST_CMD;
        cnt   <= '0;
      end else if (fall) begin
        unique case (state)
          ST_CMD: begin
            cmdReg <= {datSync[1], cmdReg[CMD_BITS-2:1]};
            if (cnt == LAST_CMD) begin
              cnt <= '0;
              if (cmdReg[3:0] == OP_LOAD)      state <= ST_LOAD;
              else if (cmdReg[3:0] == OP_READ) state <= ST_READ;
              else                             state <= ST_CMD;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_LOAD, ST_READ: begin
            if (cnt == LAST_CLK) begin
              cnt   <= '0;
              state <= ST_CMD;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: state <= ST_CMD;
        endcase
      end
    end
  end

  always_comb begin
    stb        = '0;
    stb.enter  = enter;
    stb.bitVal = datSync[1];
    if (modeEn && !enter) begin
      unique case (state)
        ST_CMD: begin
          if (fall && cnt == LAST_CMD) begin
            stb.doInc   = (cmdReg[3:0] == OP_INC);
            stb.doRead  = (cmdReg[3:0] == OP_READ);
            stb.doProg  = (cmdReg[3:0] == OP_BEGIN);
            stb.doEnd   = (cmdReg[3:0] == OP_END);
            stb.doErase = (cmdReg[3:0] == OP_ERASE);
          end
        end
        ST_LOAD: begin
          stb.shiftIn  = fall && (cnt != '0) && (cnt != LAST_CLK);
          stb.loadDone = fall && (cnt == LAST_CLK);
        end
        ST_READ: begin
          // rising edge number is the count of falls so far plus one
          stb.outStart = rise && (cnt == CW'(1));
          stb.outShift = rise && (cnt > CW'(1)) && (cnt < CW'(FRAME_CLKS - 1));
          stb.outStop  = rise && (cnt == LAST_CLK);
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/sp_dpath.sv
module sp_dpath
  import sp_pkg::*;
#(
  parameter int USER_WORDS = 256,
  parameter int CFG_USED   = 5,
  parameter int PROT_LO    = 64,
  parameter int WORD_W     = 12,
  parameter int FRAME_W    = 14,
  localparam int AW        = $clog2(USER_WORDS) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeEn,
  input  logic              cpBit,
  input  spStrobe_t         stb,
  output logic              sDatOut,
  output logic              sDatOe,
  output logic [AW-1:0]     memAddr,
  output logic              memRdEn,
  input  logic [WORD_W-1:0] memRdData,
  output logic              memWrEn,
  output logic [WORD_W-1:0] memWrData,
  output logic              memEndEn,
  output logic              memEraseEn,
  output logic              memEraseAll,
  output logic              progErr
);

  localparam logic [AW-1:0] USER_LAST = AW'(USER_WORDS - 1);
  localparam logic [AW-1:0] CFG_BASE  = AW'(USER_WORDS);
  localparam logic [AW-1:0] CFG_LAST  = AW'(USER_WORDS + CFG_USED - 1);
  localparam logic [AW-1:0] TOP_ADDR  = '1;
  localparam logic [AW-1:0] PROT_ADDR = AW'(PROT_LO);

  logic [AW-1:0]      addrCnt;
  logic               cfgVis;
  logic               loadPend;
  logic               rdPend;
  logic [FRAME_W-1:0] inShift;
  logic [FRAME_W-1:0] outShift;
  logic [WORD_W-1:0]  loadLatch;
  logic               isUser;
  logic               reachable;
  logic               hidden;

  assign isUser    = (addrCnt < CFG_BASE);
  assign reachable = cfgVis | isUser | (addrCnt <= CFG_LAST);
  assign hidden    = !cpBit && !cfgVis && isUser
                     && (addrCnt >= PROT_ADDR) && (addrCnt != USER_LAST);
  assign memAddr   = cfgVis ? TOP_ADDR : addrCnt;
  assign memWrData = loadLatch;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrCnt     <= '0;
      cfgVis      <= 1'b0;
      loadPend    <= 1'b0;
      rdPend      <= 1'b0;
      inShift     <= '0;
      outShift    <= '0;
      loadLatch   <= '0;
      sDatOut     <= 1'b0;
      sDatOe      <= 1'b0;
      memRdEn     <= 1'b0;
      memWrEn     <= 1'b0;
      memEndEn    <= 1'b0;
      memEraseEn  <= 1'b0;
      memEraseAll <= 1'b0;
      progErr     <= 1'b0;
    end else begin
      memRdEn    <= 1'b0;
      memWrEn    <= 1'b0;
      memEndEn   <= 1'b0;
      memEraseEn <= 1'b0;
      rdPend     <= 1'b0;
      if (!modeEn) begin
        sDatOe   <= 1'b0;
        progErr  <= 1'b0;
        loadPend <= 1'b0;
      end else if (stb.enter) begin
        addrCnt  <= '0;
        cfgVis   <= 1'b1;
        progErr  <= 1'b0;
        loadPend <= 1'b0;
        sDatOe   <= 1'b0;
      end else begin
        if (stb.shiftIn) inShift <= {stb.bitVal, inShift[FRAME_W-1:1]};
        if (stb.loadDone) begin
          loadLatch <= inShift[WORD_W-1:0];
          loadPend  <= 1'b1;
        end
        if (stb.doInc) begin
          if (cfgVis)                    cfgVis  <= 1'b0;
          else if (addrCnt == USER_LAST) addrCnt <= CFG_BASE;
          else if (addrCnt == TOP_ADDR)  addrCnt <= '0;
          else                           addrCnt <= addrCnt + 1'b1;
        end
        if (stb.doRead) begin
          memRdEn <= 1'b1;
          rdPend  <= 1'b1;
        end
        if (rdPend) outShift <= (reachable && !hidden) ? FRAME_W'(memRdData) : '0;
        if (stb.outStart || stb.outShift) begin
          sDatOut  <= outShift[0];
          outShift <= {1'b0, outShift[FRAME_W-1:1]};
        end
        if (stb.outStart) sDatOe <= 1'b1;
        if (stb.outStop)  sDatOe <= 1'b0;
        if (stb.doProg) begin
          if (loadPend) begin
            loadPend <= 1'b0;
            memWrEn  <= reachable;
          end else begin
            progErr <= 1'b1;
          end
        end
        if (stb.doEnd) memEndEn <= 1'b1;
        if (stb.doErase) begin
          memEraseEn  <= 1'b1;
          memEraseAll <= !cfgVis && !isUser;
        end
      end
    end
  end

endmodule

// File: rtl/sp_target.sv
module sp_target
  import sp_pkg::*;
#(
  parameter int USER_WORDS = 256,
  parameter int CFG_USED   = 5,
  parameter int PROT_LO    = 64,
  parameter int WORD_W     = 12,
  parameter int FRAME_W    = 14,
  localparam int AW        = $clog2(USER_WORDS) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeEn,
  input  logic              sClk,
  input  logic              sDatIn,
  input  logic              cpBit,
  output logic              sDatOut,
  output logic              sDatOe,
  output logic [AW-1:0]     memAddr,
  output logic              memRdEn,
  input  logic [WORD_W-1:0] memRdData,
  output logic              memWrEn,
  output logic [WORD_W-1:0] memWrData,
  output logic              memEndEn,
  output logic              memEraseEn,
  output logic              memEraseAll,
  output logic              progErr
);

  spStrobe_t stb;

  sp_ctrl #(
    .FRAME_CLKS(FRAME_W + 2),
    .CMD_BITS  (6)
  ) i_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .modeEn(modeEn),
    .sClk  (sClk),
    .sDatIn(sDatIn),
    .stb   (stb)
  );

  sp_dpath #(
    .USER_WORDS(USER_WORDS),
    .CFG_USED  (CFG_USED),
    .PROT_LO   (PROT_LO),
    .WORD_W    (WORD_W),
    .FRAME_W   (FRAME_W)
  ) i_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .modeEn     (modeEn),
    .cpBit      (cpBit),
    .stb        (stb),
    .sDatOut    (sDatOut),
    .sDatOe     (sDatOe),
    .memAddr    (memAddr),
    .memRdEn    (memRdEn),
    .memRdData  (memRdData),
    .memWrEn    (memWrEn),
    .memWrData  (memWrData),
    .memEndEn   (memEndEn),
    .memEraseEn (memEraseEn),
    .memEraseAll(memEraseAll),
    .progErr    (progErr)
  );

endmodule

// File: rtl/sp_target_chk.sv
module sp_target_chk #(
  parameter int USER_WORDS = 256,
  parameter int CFG_USED   = 5,
  localparam int AW        = $clog2(USER_WORDS) + 1
) (
  input logic          clk,
  input logic          rstN,
  input logic          modeEn,
  input logic          sDatOe,
  input logic [AW-1:0] memAddr,
  input logic          memRdEn,
  input logic          memWrEn,
  input logic          memEndEn,
  input logic          memEraseEn,
  input logic          memEraseAll,
  input logic          progErr
);

  localparam logic [AW-1:0] CFG_BASE = AW'(USER_WORDS);
  localparam logic [AW-1:0] CFG_LAST = AW'(USER_WORDS + CFG_USED - 1);
  localparam logic [AW-1:0] TOP_ADDR = '1;

  assert_mem_onehot_R11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({memRdEn, memWrEn, memEndEn, memEraseEn}));

  assert_wr_pulse_R11: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |=> !memWrEn);

  assert_erase_pulse_R11: assert property (@(posedge clk) disable iff (!rstN)
    memEraseEn |=> !memEraseEn);

  assert_oe_idle_R3: assert property (@(posedge clk) disable iff (!rstN)
    !modeEn |=> !sDatOe);

  assert_entry_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(modeEn) |=> (memAddr == TOP_ADDR) && !progErr);

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    ($past(progErr) && $past(modeEn) && $past(modeEn, 2)) |-> progErr);

  assert_erase_all_R10: assert property (@(posedge clk) disable iff (!rstN)
    (memEraseEn && memEraseAll) |-> (memAddr >= CFG_BASE));

  assert_wr_reach_R6: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> ((memAddr <= CFG_LAST) || (memAddr == TOP_ADDR)));

endmodule

bind sp_target sp_target_chk #(
  .USER_WORDS(USER_WORDS),
  .CFG_USED  (CFG_USED)
) i_chk (
  .clk        (clk),
  .rstN       (rstN),
  .modeEn     (modeEn),
  .sDatOe     (sDatOe),
  .memAddr    (memAddr),
  .memRdEn    (memRdEn),
  .memWrEn    (memWrEn),
  .memEndEn   (memEndEn),
  .memEraseEn (memEraseEn),
  .memEraseAll(memEraseAll),
  .progErr    (progErr)
);

// File: tb/test_sp_target.sv
`timescale 1ns/1ps
module test_sp_target;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        modeEn = 1'b0;
  logic        sClk = 1'b0;
  logic        sDatIn = 1'b0;
  logic        cpBit = 1'b1;
  logic        sDatOut;
  logic        sDatOe;
  logic [8:0]  memAddr;
  logic        memRdEn;
  logic [11:0] memRdData = '0;
  logic        memWrEn;
  logic [11:0] memWrData;
  logic        memEndEn;
  logic        memEraseEn;
  logic        memEraseAll;
  logic        progErr;

  int nTests = 0;
  int nFail  = 0;

  // memory model and monitor counters
  logic [11:0] mem [512];
  int          wrCnt = 0, endCnt = 0, eraseCnt = 0;
  logic [8:0]  lastWrAddr = '0;
  logic [11:0] lastWrData = '0;
  logic        lastEraseAll = 1'b0;

  // reference state
  logic [11:0] refMem [512];
  int          refCnt = 0;
  bit          refVis = 1'b0;
  bit          refPend = 1'b0;
  bit          refErr = 1'b0;
  logic [11:0] refLatch = '0;

  always #5 clk = ~clk;

  sp_target i_sp_target (
    .clk(clk), .rstN(rstN), .modeEn(modeEn), .sClk(sClk), .sDatIn(sDatIn),
    .cpBit(cpBit), .sDatOut(sDatOut), .sDatOe(sDatOe), .memAddr(memAddr),
    .memRdEn(memRdEn), .memRdData(memRdData), .memWrEn(memWrEn),
    .memWrData(memWrData), .memEndEn(memEndEn), .memEraseEn(memEraseEn),
    .memEraseAll(memEraseAll), .progErr(progErr)
  );

  always @(negedge clk) begin
    if (memRdEn) memRdData <= mem[memAddr];
    if (memWrEn) begin
      mem[memAddr] = memWrData;
      wrCnt++;
      lastWrAddr = memAddr;
      lastWrData = memWrData;
    end
    if (memEndEn) endCnt++;
    if (memEraseEn) begin
      eraseCnt++;
      lastEraseAll = memEraseAll;
      for (int i = 0; i < 256; i++) mem[i] = 12'hFFF;
      mem[511] = 12'hFFF;
      if (memEraseAll) for (int i = 256; i < 261; i++) mem[i] = 12'hFFF;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clkBit(input logic b);
    sDatIn = b;
    sClk   = 1'b1;
    waitCyc(8);
    sClk   = 1'b0;
    waitCyc(8);
  endtask

  task automatic sendCmd(input logic [3:0] op);
    logic [5:0] c;
    c = {2'($urandom_range(0, 3)), op};
    for (int i = 0; i < 6; i++) clkBit(c[i]);
    waitCyc(12);
  endtask

  function automatic int expAddr();
    return refVis ? 511 : refCnt;
  endfunction

  function automatic bit refReach();
    return refVis || refCnt <= 260;
  endfunction

  function automatic logic [13:0] refRead();
    if (refVis) return {2'b00, refMem[511]};
    if (refCnt >= 261) return '0;
    if (refCnt < 256 && !cpBit && refCnt >= 64 && refCnt != 255) return '0;
    return {2'b00, refMem[refCnt]};
  endfunction

  task automatic doLoad(input logic [13:0] w);
    sendCmd(4'h2);
    for (int k = 1; k <= 16; k++)
      clkBit((k == 1 || k == 16) ? 1'($urandom_range(0, 1)) : w[k-2]);
    waitCyc(12);
    refPend  = 1'b1;
    refLatch = w[11:0];
  endtask

  task automatic doInc();
    sendCmd(4'h6);
    if (refVis) refVis = 1'b0;
    else if (refCnt == 255) refCnt = 256;
    else if (refCnt == 511) refCnt = 0;
    else refCnt++;
    check(memAddr == 9'(expAddr()), "R5 address after increment", memAddr, expAddr());
  endtask

  task automatic doRead();
    logic [13:0] got;
    logic [13:0] exp;
    bit          oeOk;
    got  = '0;
    oeOk = 1'b1;
    exp  = refRead();
    sendCmd(4'h4);
    for (int k = 1; k <= 16; k++) begin
      sDatIn = 1'($urandom_range(0, 1));
      sClk   = 1'b1;
      waitCyc(6);
      if (sDatOe !== (k >= 2 && k <= 15)) oeOk = 1'b0;
      if (k >= 2 && k <= 15) got[k-2] = sDatOut;
      waitCyc(2);
      sClk = 1'b0;
      waitCyc(8);
    end
    waitCyc(12);
    check(oeOk, "R3 output enable window", oeOk, 1);
    check(got == exp, "R3/R6/R7 read value", got, exp);
  endtask

  task automatic doProg();
    int w0;
    w0 = wrCnt;
    sendCmd(4'h8);
    if (refPend) begin
      refPend = 1'b0;
      if (refReach()) begin
        refMem[expAddr()] = refLatch;
        check(wrCnt == w0 + 1 && lastWrAddr == 9'(expAddr()) && lastWrData == refLatch,
              "R8 write issued", {wrCnt[11:0], lastWrData}, {12'(w0 + 1), refLatch});
      end else begin
        check(wrCnt == w0, "R6 write suppressed", wrCnt, w0);
      end
    end else begin
      refErr = 1'b1;
      check(wrCnt == w0, "R8 no write without load", wrCnt, w0);
    end
    check(progErr == refErr, "R8 error flag", progErr, refErr);
  endtask

  task automatic doEnd();
    int e0;
    e0 = endCnt;
    sendCmd(4'hE);
    check(endCnt == e0 + 1, "R9 end pulse", endCnt, e0 + 1);
  endtask

  task automatic doErase();
    int  e0;
    bit  all;
    e0  = eraseCnt;
    all = !refVis && refCnt >= 256;
    sendCmd(4'h9);
    for (int i = 0; i < 256; i++) refMem[i] = 12'hFFF;
    refMem[511] = 12'hFFF;
    if (all) for (int i = 256; i < 261; i++) refMem[i] = 12'hFFF;
    check(eraseCnt == e0 + 1 && lastEraseAll == all, "R10 erase scope",
          lastEraseAll, all);
  endtask

  task automatic enterMode();
    modeEn = 1'b0;
    waitCyc(10);
    modeEn = 1'b1;
    waitCyc(10);
    refCnt  = 0;
    refVis  = 1'b1;
    refPend = 1'b0;
    refErr  = 1'b0;
    check(memAddr == 9'h1FF, "R4 entry selects configuration word", memAddr, 9'h1FF);
    check(progErr == 1'b0, "R4 entry clears error", progErr, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nTests++;
    nFail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    int seedDummy;
    int a0, w0, e0, r0;
    seedDummy = $urandom(32'h5EED1234);
    for (int i = 0; i < 512; i++) begin
      mem[i]    = 12'($urandom());
      refMem[i] = mem[i];
    end
    waitCyc(5);
    rstN = 1'b1;
    waitCyc(5);
    check(sDatOe == 1'b0 && progErr == 1'b0 && memWrEn == 1'b0,
          "R4 reset state", {sDatOe, progErr, memWrEn}, 0);

    enterMode();
    doRead();                       // configuration word visible
    doLoad(14'h3ABC);               // top two bits dropped (R2)
    doProg();
    doRead();
    doErase();                      // configuration word selected: IDs kept

    // unknown command leaves everything alone (R1)
    a0 = memAddr; w0 = wrCnt; e0 = eraseCnt; r0 = endCnt;
    sendCmd(4'hA);
    sendCmd(4'h0);
    check(memAddr == 9'(a0) && wrCnt == w0 && eraseCnt == e0 && endCnt == r0,
          "R1 unknown code ignored", memAddr, a0);

    doInc();                        // to 0x000, configuration word gone
    cpBit = 1'b0;
    for (int i = 0; i < 63; i++) doInc();
    doRead();                       // 0x03F unprotected (R7)
    doInc();
    doRead();                       // 0x040 hidden (R7)
    while (refCnt != 255) doInc();
    doRead();                       // last user word unprotected
    doInc();                        // 0x0FF -> 0x100 (R5)
    check(memAddr == 9'h100, "R5 user to configuration step", memAddr, 9'h100);
    doRead();
    doLoad(14'h1234);
    doProg();
    doRead();                       // user ID location
    doErase();                      // config space: IDs erased (R10)
    doRead();
    while (refCnt != 511) doInc();
    doRead();                       // 0x1FF no longer the configuration word (R6)
    doLoad(14'h0555);
    doProg();                       // suppressed (R6)
    doInc();                        // wrap to zero (R5)
    check(memAddr == 9'h000, "R5 top wraps to zero", memAddr, 0);
    doProg();                       // no load pending: error (R8)
    doEnd();

    modeEn = 1'b0;
    waitCyc(10);
    check(sDatOe == 1'b0 && progErr == 1'b0, "R4 idle when mode off", progErr, 0);
    enterMode();
    cpBit = 1'b1;

    for (int n = 0; n < 140; n++) begin
      int op;
      op = $urandom_range(0, 9);
      if ($urandom_range(0, 7) == 0) cpBit = ~cpBit;
      case (op)
        0, 1, 2: begin doLoad(14'($urandom())); doProg(); end
        3, 4: for (int j = $urandom_range(1, 12); j > 0; j--) doInc();
        5, 6: doRead();
        7: doProg();
        8: doEnd();
        default: if ($urandom_range(0, 3) == 0) doErase(); else doInc();
      endcase
    end

    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule